// File: doc/BRIEF.md
# Sixteen-bit pulse train generator

This block is a free-running 16-bit up-counter with two compare registers that together shape a repeating pulse on one output pin. One compare value sets where inside a period the pin changes level (the pulse width). The other compare value sets the period length. When the count reaches the width value, the output flip-flop inverts and counting carries on. When the count reaches the period value, the flip-flop inverts again, the counter returns to zero and a one-cycle interrupt pulse is raised.

The pin always shows the complement of the internal flip-flop. Software chooses the flip-flop's starting level while the timer is idle, which selects between positive and negative pulses. The count tick comes from one of three taps of an internal prescaler, or from the rising edges of an external clock pin after synchronization.

Software programs the block through a byte-wide write port. Each compare register takes two byte writes, low byte before high byte. Both compare registers are used directly with no shadow copy, so a write changes the pulse shape from the next tick onward.

Top module: `pulse_train_gen`

## Requirements
- R1: While running, the counter advances by one on each tick. Clock select value 0 ticks every cycle, 1 ticks every 4th cycle, 2 ticks every 16th cycle, and 3 ticks once per synchronized rising edge of `extClkIn`. The prescaler restarts when counting starts.
- R2: When the advanced count equals the width register, the output flip-flop inverts and the counter keeps counting without clearing.
- R3: When the advanced count equals the period register, the flip-flop inverts, the counter returns to 0 and `irqPulse` is high for exactly that one cycle. The period match takes priority over the width match. With width W and period P (0 < W < P), the pin spends W ticks at its first level and P ticks per period.
- R4: After reset the flip-flop is 0, so `pulseOut` is 1. `irqPulse` is 0 and the timer is stopped, so the pin does not move.
- R5: `pulseOut` is the inverse of the flip-flop. A control write made while stopped loads the flip-flop from control bit 3, so level 0 gives pulses that start high and level 1 gives pulses that start low.
- R6: Register addresses are 0 (width low byte), 1 (width high byte), 2 (period low byte), 3 (period high byte) and 4 (control). Control bit 0 is run, bits 2:1 are clock select, and bit 3 is the start level.
- R7: A compare write made while running takes effect from the next tick, even inside the current period.
- R8: Clearing the run bit freezes the counter and holds the pin at its present level with no interrupt. A start-level value written while running is ignored.
- R9: `extClkIn` passes through a two-stage synchronizer. Each rising edge counts exactly once, however long the pin stays high. The pin must stay high and stay low for at least two cycles each.
- R10: Setting run while stopped restarts counting from zero.
- R11: With a tick every cycle, width 2000 and period 0x8002, the pin is high for 2000 cycles and the period is 32770 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Write data byte |
| extClkIn | input | 1 | External count clock, asynchronous |
| pulseOut | output | 1 | Pulse output, inverse of the output flip-flop |
| irqPulse | output | 1 | One-cycle pulse at each period match |

## Verification
The bench sweeps every width and period pair up to a period of 8 at full tick rate, plus smaller sets at the two divided rates. It predicts each cycle's pin and interrupt from the tick count. Any off-by-one in the compare, such as matching the old count instead of the advanced one, or clearing on the width match, shifts a pin edge and shows up at once.

Other tests target the harder cases:
- A width change mid-period must give a second toggle in the same period. A design that buffered the compare would miss it.
- A start-level write during a run must leave the pin unchanged.
- After a stop, the pin must hold. A restart must begin from zero, so a design that resumed from the frozen count would put the first edge too early.
- External pulses of different lengths must each count once. A level-sensitive design would count a long pulse many times.

// File: rtl/pulse_train_pkg.sv
package pulse_train_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd4;

  localparam int CTRL_RUN_BIT   = 0;
  localparam int CTRL_SEL_LSB   = 1;
  localparam int CTRL_LEVEL_BIT = 3;

  localparam logic [1:0] SEL_EXT = 2'd3;

  typedef struct packed {
    logic tick;      // advance the counter this cycle
    logic clearCnt;  // start from zero
    logic loadFf;    // preset the output flip-flop
    logic ffInit;    // preset value
  } ctrlStrobe_t;

endpackage

// File: rtl/ptg_control.sv
module ptg_control
  import pulse_train_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SHIFT0 = 0,
  parameter int SHIFT1 = 2,
  parameter int SHIFT2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              extClkIn,
  output logic [CNT_W-1:0]  widthVal,
  output logic [CNT_W-1:0]  periodVal,
  output ctrlStrobe_t       strobe
);

  localparam int BYTES  = CNT_W / 8;
  localparam int MAX01  = (SHIFT0 > SHIFT1) ? SHIFT0 : SHIFT1;
  localparam int MAXSH  = (MAX01 > SHIFT2) ? MAX01 : SHIFT2;
  localparam int PRE_W  = (MAXSH > 0) ? MAXSH : 1;

  logic [7:0] widthB  [BYTES];
  logic [7:0] periodB [BYTES];

  // Compare bytes: written straight into the live registers, no shadow.
  for (genvar b = 0; b < BYTES; b++) begin : g_bytes
    localparam logic [ADDR_W-1:0] W_ADDR = ADDR_W'(b);
    localparam logic [ADDR_W-1:0] P_ADDR = ADDR_W'(BYTES + b);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        widthB[b]  <= '0;
        periodB[b] <= '0;
      end else if (wrEn) begin
        if (wrAddr == W_ADDR) widthB[b]  <= wrData;
        if (wrAddr == P_ADDR) periodB[b] <= wrData;
      end
    end

    assign widthVal[b*8 +: 8]  = widthB[b];
    assign periodVal[b*8 +: 8] = periodB[b];
  end

  // Control register
  logic       runQ;
  logic [1:0] selQ;
  logic       ctrlWr;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0;
      selQ <= 2'd0;
    end else if (ctrlWr) begin
      runQ <= wrData[CTRL_RUN_BIT];
      selQ <= wrData[CTRL_SEL_LSB +: 2];
    end
  end

  // Prescaler: held at zero while stopped so each run starts aligned
  logic [PRE_W-1:0] preQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      preQ <= '0;
    else if (!runQ) preQ <= '0;
    else            preQ <= preQ + 1'b1;
  end

  // External clock: two-stage synchronizer plus edge register
  logic syncA, syncB, syncC, extRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= extClkIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign extRise = syncB & ~syncC;

  // Tick sources: three prescaler taps plus the external edge
  logic [3:0] tapVec;

  for (genvar k = 0; k < 3; k++) begin : g_taps
    localparam int SH = (k == 0) ? SHIFT0 : ((k == 1) ? SHIFT1 : SHIFT2);
    if (SH == 0) begin : g_every
      assign tapVec[k] = 1'b1;
    end else begin : g_div
      assign tapVec[k] = &preQ[SH-1:0];
    end
  end
  assign tapVec[SEL_EXT] = extRise;

  always_comb begin
    strobe.tick     = runQ && tapVec[selQ];
    strobe.clearCnt = ctrlWr && wrData[CTRL_RUN_BIT] && !runQ;
    strobe.loadFf   = ctrlWr && !runQ;
    strobe.ffInit   = wrData[CTRL_LEVEL_BIT];
  end

  // R9: one rising edge gives one count enable, never two in a row
  a_r9_single_edge: assert property (@(posedge clk) disable iff (!rstN)
    extRise |=> !extRise);

  // R10: the prescaler begins a new run from zero
  a_r10_prescale_restart: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> (preQ == '0));

endmodule

// File: rtl/ptg_datapath.sv
module ptg_datapath
  import pulse_train_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [CNT_W-1:0] widthVal,
  input  logic [CNT_W-1:0] periodVal,
  output logic             ffOut,
  output logic             irqOut
);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] nextCnt;
  logic             ffQ;
  logic             irqQ;

  assign nextCnt = cntQ + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      ffQ  <= 1'b0;
      irqQ <= 1'b0;
    end else begin
      irqQ <= 1'b0;
      if (strobe.clearCnt) cntQ <= '0;
      if (strobe.loadFf)   ffQ  <= strobe.ffInit;
      if (strobe.tick) begin
        if (nextCnt == periodVal) begin
          cntQ <= '0;
          ffQ  <= ~ffQ;
          irqQ <= 1'b1;
        end else begin
          cntQ <= nextCnt;
          if (nextCnt == widthVal) ffQ <= ~ffQ;
        end
      end
    end
  end

  assign ffOut  = ffQ;
  assign irqOut = irqQ;

  // R3: an interrupt only follows a tick, and leaves the counter at zero
  a_r3_irq_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> $past(strobe.tick));

  a_r3_irq_clears: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> (cntQ == '0));

  // R1: a tick without a period match steps the count by exactly one
  a_r1_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && (nextCnt != periodVal)) |=> (cntQ == $past(cntQ) + 1'b1));

  // R8: with no tick, start or preset, counter and flip-flop stay put
  a_r8_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.clearCnt && !strobe.loadFf)
      |=> ($stable(cntQ) && $stable(ffQ) && !irqQ));

endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen
  import pulse_train_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SHIFT0 = 0,
  parameter int SHIFT1 = 2,
  parameter int SHIFT2 = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       extClkIn,
  output logic       pulseOut,
  output logic       irqPulse
);

  logic [CNT_W-1:0] widthVal;
  logic [CNT_W-1:0] periodVal;
  ctrlStrobe_t      strobe;
  logic             ffOut;

  ptg_control #(
    .CNT_W(CNT_W), .SHIFT0(SHIFT0), .SHIFT1(SHIFT1), .SHIFT2(SHIFT2)
  ) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .extClkIn  (extClkIn),
    .widthVal  (widthVal),
    .periodVal (periodVal),
    .strobe    (strobe)
  );

  ptg_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .widthVal  (widthVal),
    .periodVal (periodVal),
    .ffOut     (ffOut),
    .irqOut    (irqPulse)
  );

  // R5: the pin shows the complement of the flip-flop
  assign pulseOut = ~ffOut;

endmodule

// File: tb/pulse_train_gen_bench.sv
`timescale 1ns/1ps
module pulse_train_gen_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       extClkIn = 1'b0;
  logic       pulseOut;
  logic       irqPulse;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pulse_train_gen u_pulse_train_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .extClkIn(extClkIn),
    .pulseOut(pulseOut), .irqPulse(irqPulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the capturing edge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [7:0] ctrlByte(input bit run, input int sel, input bit lvl);
    return {4'b0, lvl, sel[1:0], run};
  endfunction

  task automatic setCfg(input int w, input int p, input int sel, input bit lvl);
    wr(3'd0, w[7:0]);  wr(3'd1, w[15:8]);   // R6 width low then high
    wr(3'd2, p[7:0]);  wr(3'd3, p[15:8]);   // R6 period low then high
    wr(3'd4, ctrlByte(1'b0, sel, lvl));
  endtask

  // Arithmetic model of one run: j edges since start, tick every div cycles
  task automatic sweepRun(input int w, input int p, input int sel,
                          input int div, input bit lvl, input int ncyc);
    setCfg(w, p, sel, lvl);
    wr(3'd4, ctrlByte(1'b1, sel, lvl));
    chk("R10 start level", pulseOut, !lvl);
    for (int j = 1; j <= ncyc; j++) begin
      int t, ph;
      bit expIrq;
      @(negedge clk);
      t  = j / div;
      ph = t % p;
      expIrq = (j % div == 0) && (t > 0) && (ph == 0);
      chk("R2 R5 pin", pulseOut, !(lvl ^ (ph >= w)));
      chk("R3 irq", irqPulse, expIrq);
    end
    wr(3'd4, ctrlByte(1'b0, sel, lvl));
  endtask

  initial begin
    int fallAt, irq1, irq2, riseAt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R4: reset state, and nothing moves while stopped
    chk("R4 pin after reset", pulseOut, 1);
    chk("R4 irq after reset", irqPulse, 0);
    repeat (10) @(negedge clk);
    chk("R4 idle pin", pulseOut, 1);

    // R1 R2 R3 R5 R10: sweep at full rate
    for (int p = 2; p <= 8; p++)
      for (int w = 1; w < p; w++)
        sweepRun(w, p, 0, 1, bit'((w + p) & 1), 3 * p);

    // R1: divide-by-4 and divide-by-16 taps
    for (int p = 2; p <= 4; p++)
      for (int w = 1; w < p; w++)
        sweepRun(w, p, 1, 4, bit'(w & 1), 12 * p + 3);
    sweepRun(1, 3, 2, 16, 1'b0, 16 * 7 + 5);

    // R7: width change mid-period acts at once
    setCfg(3, 10, 0, 1'b0);
    wr(3'd4, ctrlByte(1'b1, 0, 1'b0));
    repeat (5) @(negedge clk);
    chk("R7 before change", pulseOut, 0);
    wr(3'd0, 8'd7);                        // edge 6
    chk("R7 count 6", pulseOut, 0);
    @(negedge clk);
    chk("R7 toggle at new width", pulseOut, 1);
    repeat (2) @(negedge clk);
    chk("R7 count 9", pulseOut, 1);
    @(negedge clk);
    chk("R7 period toggle", pulseOut, 0);
    chk("R7 period irq", irqPulse, 1);
    wr(3'd4, ctrlByte(1'b0, 0, 1'b0));

    // R8: level ignored while running; stop holds pin
    setCfg(3, 6, 0, 1'b0);
    wr(3'd4, ctrlByte(1'b1, 0, 1'b0));
    @(negedge clk);                        // j=1
    wr(3'd4, ctrlByte(1'b1, 0, 1'b1));     // j=2
    chk("R8 level ignored while running", pulseOut, 1);
    repeat (2) @(negedge clk);             // j=4
    chk("R8 pin before stop", pulseOut, 0);
    wr(3'd4, ctrlByte(1'b0, 0, 1'b1));     // stop; level ignored (was running)
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R8 hold pin", pulseOut, 0);
      chk("R8 no irq", irqPulse, 0);
    end
    wr(3'd4, ctrlByte(1'b0, 0, 1'b0));     // stopped: preset level 0
    chk("R5 preset while stopped", pulseOut, 1);

    // R9: external clock, pulses of differing lengths count once each
    setCfg(2, 3, 3, 1'b0);
    wr(3'd4, ctrlByte(1'b1, 3, 1'b0));
    for (int k = 1; k <= 9; k++) begin
      extClkIn = 1'b1;
      repeat (2 + 2 * (k % 3)) @(negedge clk);
      extClkIn = 1'b0;
      repeat (6) @(negedge clk);
      chk("R9 ext count", pulseOut, !((k % 3) >= 2));
    end
    wr(3'd4, ctrlByte(1'b0, 3, 1'b0));

    // R11: 2000-tick high time in a 32770-tick period
    setCfg(2000, 32770, 0, 1'b0);
    wr(3'd4, ctrlByte(1'b1, 0, 1'b0));
    fallAt = -1; irq1 = -1; irq2 = -1; riseAt = -1;
    for (int j = 1; j <= 65545; j++) begin
      @(negedge clk);
      if (fallAt < 0 && pulseOut == 1'b0) fallAt = j;
      if (fallAt >= 0 && riseAt < 0 && pulseOut == 1'b1) riseAt = j;
      if (irqPulse) begin
        if (irq1 < 0) irq1 = j;
        else if (irq2 < 0) irq2 = j;
      end
    end
    chk("R11 high time", fallAt, 2000);
    chk("R11 first period end", irq1, 32770);
    chk("R11 rise at period end", riseAt, 32770);
    chk("R11 second period end", irq2, 65540);
    wr(3'd4, ctrlByte(1'b0, 0, 1'b0));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule